// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the device-side command front end of a small serial NOR flash. It watches the SPI pins (clock, active-low select, serial in) from its own system clock, assembles each frame into bytes and classifies the first byte through an opcode table. That table gives, for each opcode, the operation class, whether a three-byte address follows, how many dummy bytes come before read data, and whether read data leaves on one line or two. The decoder then either starts a read stream, forwards program data bytes, or, when the frame closes cleanly, issues one erase or program request to a downstream array controller.

Read bytes are fetched one ahead through a request/valid pair at an address that counts up and wraps at the top of the 16-bit space, and are shifted out on the serial output (or on both data lines for the dual read). A write-enable latch gates every program and erase. Frames that close mid-byte or before their address is complete, and frames with an opcode the table does not know, leave no trace at the array side.

Top module: `sflash_cmd_decoder`

## Requirements
- R1: A frame starts when spi_cs_n falls. Its first 8 bits sampled on rising SCK are the opcode, MSB first. Opcodes with an address take the next 3 bytes MSB first; of those 24 bits only the low 16 are kept, so 0x123456 yields address 0x3456.
- R2: An opcode outside {03h, 0Bh, 3Bh, 81h, 20h, 52h, D8h, 60h, C7h, 62h, 02h, 9Bh, 06h, 04h} produces no request of any kind (cmd_valid, wr_valid, rd_req stay low, the latch keeps its value). The rest of that frame is ignored.
- R3: If spi_cs_n rises before the opcode and any required address bytes are complete, or at a point that is not a whole number of bytes into the frame, nothing is issued and the latch is unchanged.
- R4: Opcode 03h starts reading right after the address and 0Bh after one further dummy byte. Each byte from rd_data leaves on spi_so MSB first, one bit per SCK falling edge. The first bit is launched by the falling edge that follows the last address or dummy bit.
- R5: One rd_req is made per read byte, at an address one higher than the previous. It wraps from 0xFFFF to 0x0000.
- R6: Opcode 3Bh reads after one dummy byte in dual mode. Each falling edge drives bits 7,5,3,1 on spi_so and bits 6,4,2,0 on spi_io0_out, in that order. spi_io0_oe is high only during a dual read, and spi_so_oe only during any read.
- R7: 06h sets the write-enable latch (output wel) and 04h clears it. Each takes effect when spi_cs_n rises on a byte boundary.
- R8: With the latch set, a cleanly closed erase frame gives one cmd_valid pulse. cmd_op is 0 for 81h, 1 for 20h, 2 for 52h and D8h, and 3 for 60h, C7h and 62h. cmd_addr is the frame address, or 0 for the three chip erase opcodes, and cmd_len is 0.
- R9: With the latch set, each data byte after the address of 02h or 9Bh appears once on wr_data with a wr_valid pulse. At a clean close after at least one data byte, cmd_valid pulses with cmd_op 4 (02h) or 5 (9Bh), the address, and the byte count in cmd_len. With no data byte there is no request.
- R10: Program data bytes beyond MAX_PROG (256) in one frame are not forwarded, and cmd_len stops at MAX_PROG.
- R11: An issued program or erase clears the latch. With the latch clear, program and erase frames forward no data and issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | Serial data out (odd bits in dual mode) |
| spi_so_oe | output | 1 | Output enable for spi_so |
| spi_io0_out | output | 1 | Even read bits driven on the data-in line in dual mode |
| spi_io0_oe | output | 1 | Output enable for the data-in line |
| wel | output | 1 | Write-enable latch state |
| cmd_valid | output | 1 | One-cycle erase/program request |
| cmd_op | output | 3 | Operation code of the request |
| cmd_addr | output | ADDR_W | Request address |
| cmd_len | output | LEN_W | Program byte count |
| wr_valid | output | 1 | Program data byte strobe |
| wr_data | output | 8 | Program data byte |
| rd_req | output | 1 | Read byte request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_valid | input | 1 | Read byte returned |
| rd_data | input | 8 | Returned read byte |

## Verification
The hardest situations to reach are the dropped ones: a select edge that lands part way through a byte, or after only some of the address bytes, while the latch is already set so that a wrongly accepted frame would show up as a request. The bench raises the latch first, then drives frames cut off at chosen bit counts, and checks that no request appears and the latch survives. A sweep over every opcode outside the table, each followed by a byte that would start an address, shows that all of them stay silent. A 258-byte program frame reaches the byte-count ceiling, and a read started two bytes below the top address crosses the wrap.

// File: rtl/sfcd_pkg.sv
package sfcd_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_ERASE = 3'd2,
    K_PROG  = 3'd3,
    K_WREN  = 3'd4,
    K_WRDI  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    OP_ERASE_PAGE = 3'd0,
    OP_ERASE_4K   = 3'd1,
    OP_ERASE_32K  = 3'd2,
    OP_ERASE_CHIP = 3'd3,
    OP_PROG       = 3'd4,
    OP_PROG_OTP   = 3'd5
  } cmd_op_e;

  typedef struct packed {
    logic       known;
    kind_e      kind;
    logic       has_addr;
    logic [1:0] dummy;
    logic       dual;
    cmd_op_e    op;
  } op_info_t;

  function automatic op_info_t mk(input kind_e k, input logic a,
                                  input logic [1:0] d, input logic du,
                                  input cmd_op_e o);
    op_info_t r;
    r.known = 1'b1; r.kind = k; r.has_addr = a;
    r.dummy = d; r.dual = du; r.op = o;
    return r;
  endfunction

  // Opcode table: class, address presence, dummy byte count, lane mode.
  function automatic op_info_t decode_opcode(input logic [7:0] opc);
    op_info_t r;
    r = '0;
    unique case (opc)
      8'h03: r = mk(K_READ,  1'b1, 2'd0, 1'b0, OP_ERASE_PAGE);
      8'h0B: r = mk(K_READ,  1'b1, 2'd1, 1'b0, OP_ERASE_PAGE);
      8'h3B: r = mk(K_READ,  1'b1, 2'd1, 1'b1, OP_ERASE_PAGE);
      8'h81: r = mk(K_ERASE, 1'b1, 2'd0, 1'b0, OP_ERASE_PAGE);
      8'h20: r = mk(K_ERASE, 1'b1, 2'd0, 1'b0, OP_ERASE_4K);
      8'h52,
      8'hD8: r = mk(K_ERASE, 1'b1, 2'd0, 1'b0, OP_ERASE_32K);
      8'h60,
      8'hC7,
      8'h62: r = mk(K_ERASE, 1'b0, 2'd0, 1'b0, OP_ERASE_CHIP);
      8'h02: r = mk(K_PROG,  1'b1, 2'd0, 1'b0, OP_PROG);
      8'h9B: r = mk(K_PROG,  1'b1, 2'd0, 1'b0, OP_PROG_OTP);
      8'h06: r = mk(K_WREN,  1'b0, 2'd0, 1'b0, OP_ERASE_PAGE);
      8'h04: r = mk(K_WRDI,  1'b0, 2'd0, 1'b0, OP_ERASE_PAGE);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sfcd_sync.sv
module sfcd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], pin_i};
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  =  chain[STAGES-1] & ~chain[STAGES];
  assign fall_o  = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/sfcd_rx.sv
module sfcd_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       sample_i,
  input  logic       si_i,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       boundary_o
);
  logic [2:0] bit_cnt;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; sh <= '0; byte_done_o <= 1'b0; byte_o <= '0;
    end else begin
      byte_done_o <= 1'b0;
      if (clear_i) begin
        bit_cnt <= '0;
      end else if (sample_i) begin
        sh      <= {sh[5:0], si_i};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done_o <= 1'b1;
          byte_o      <= {sh, si_i};
        end
      end
    end
  end

  assign boundary_o = (bit_cnt == 3'd0);

  p_byte_on_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> boundary_o);
endmodule

// File: rtl/sfcd_tx.sv
module sfcd_tx #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dual_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stop_i,
  input  logic              shift_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              io0_o,
  output logic              io0_oe_o
);
  logic              active, dual, full;
  logic [7:0]        hold, sh;
  logic [2:0]        cnt;
  logic [ADDR_W-1:0] nxt;
  logic [7:0]        load;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  assign load = full ? hold : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; dual <= 1'b0; full <= 1'b0; hold <= '0; sh <= '0;
      cnt <= '0; nxt <= '0; rd_req_o <= 1'b0; rd_addr_o <= '0;
      so_o <= 1'b0; io0_o <= 1'b0;
    end else begin
      rd_req_o <= 1'b0;
      if (stop_i) begin
        active <= 1'b0; full <= 1'b0; so_o <= 1'b0; io0_o <= 1'b0;
      end else if (start_i) begin
        active    <= 1'b1;
        dual      <= dual_i;
        full      <= 1'b0;
        cnt       <= '0;
        rd_req_o  <= 1'b1;
        rd_addr_o <= addr_i;
        nxt       <= bump(addr_i);
      end else begin
        if (active && shift_i) begin
          if (cnt == 3'd0) begin
            so_o      <= load[7];
            io0_o     <= dual ? load[6] : 1'b0;
            sh        <= dual ? {load[5:0], 2'b00} : {load[6:0], 1'b0};
            cnt       <= dual ? 3'd3 : 3'd7;
            full      <= 1'b0;
            rd_req_o  <= 1'b1;
            rd_addr_o <= nxt;
            nxt       <= bump(nxt);
          end else begin
            so_o  <= sh[7];
            io0_o <= dual ? sh[6] : 1'b0;
            sh    <= dual ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
            cnt   <= cnt - 3'd1;
          end
        end
        if (active && rd_valid_i) begin
          hold <= rd_data_i;
          full <= 1'b1;
        end
      end
    end
  end

  assign so_oe_o  = active;
  assign io0_oe_o = active & dual;

  p_dual_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe_o |-> so_oe_o);
  p_req_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> so_oe_o);
  p_req_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(rd_req_o) == 1'b0 && $past(active) && active)
      |-> rd_addr_o == bump($past(rd_addr_o)) || $past(start_i));
endmodule

// File: rtl/sflash_cmd_decoder.sv
module sflash_cmd_decoder
  import sfcd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MAX_PROG    = 256,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAX_PROG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              spi_io0_out,
  output logic              spi_io0_oe,
  output logic              wel,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_READ, ST_DATA, ST_ARMED, ST_IGNORE
  } state_e;

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PROG);

  // pin synchronisers
  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic si_lvl, si_rise_unused, si_fall_unused;

  sfcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_cs_n),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
  sfcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_sck),
    .level_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));
  sfcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_si),
    .level_o(si_lvl), .rise_o(si_rise_unused), .fall_o(si_fall_unused));

  logic cs_low;
  assign cs_low = ~cs_lvl;

  // byte assembly
  logic       byte_done, rx_boundary;
  logic [7:0] rx_byte;

  sfcd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clear_i(cs_fall),
    .sample_i(sck_rise & cs_low & ~cs_fall), .si_i(si_lvl),
    .byte_done_o(byte_done), .byte_o(rx_byte), .boundary_o(rx_boundary));

  // frame state
  state_e            state;
  op_info_t          info, info_now;
  logic [23:0]       addr_sh, addr_full;
  logic [1:0]        idx;
  logic [LEN_W-1:0]  dcnt;
  logic              wel_q;

  assign info_now  = decode_opcode(rx_byte);
  assign addr_full = {addr_sh[15:0], rx_byte};

  // named events
  logic unknown_evt, addr_last, read_start, start_direct, start_dummy;
  logic frame_ok, issue_evt, data_take;
  logic [ADDR_W-1:0] start_addr;

  assign unknown_evt  = byte_done && state == ST_OPC && !info_now.known;
  assign addr_last    = byte_done && state == ST_ADDR && idx == 2'd2;
  assign start_direct = addr_last && info.kind == K_READ && info.dummy == 2'd0;
  assign start_dummy  = byte_done && state == ST_DUMMY && idx == info.dummy - 2'd1;
  assign read_start   = !cs_rise && !cs_fall && (start_direct || start_dummy);
  assign start_addr   = start_direct ? addr_full[ADDR_W-1:0] : addr_sh[ADDR_W-1:0];
  assign frame_ok     = cs_rise && rx_boundary &&
                        (state == ST_ARMED || (state == ST_DATA && dcnt != '0));
  assign issue_evt    = frame_ok && wel_q &&
                        (info.kind == K_ERASE || info.kind == K_PROG);
  assign data_take    = byte_done && state == ST_DATA && dcnt != LEN_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; info <= '0; addr_sh <= '0; idx <= '0; dcnt <= '0;
      wel_q <= 1'b0; cmd_valid <= 1'b0; cmd_op <= '0; cmd_addr <= '0;
      cmd_len <= '0; wr_valid <= 1'b0; wr_data <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (cs_rise) begin
        if (frame_ok) begin
          case (info.kind)
            K_WREN:  wel_q <= 1'b1;
            K_WRDI:  wel_q <= 1'b0;
            default: if (issue_evt) begin
              cmd_valid <= 1'b1;
              cmd_op    <= info.op;
              cmd_addr  <= addr_sh[ADDR_W-1:0];
              cmd_len   <= (info.kind == K_PROG) ? dcnt : '0;
              wel_q     <= 1'b0;
            end
          endcase
        end
        state <= ST_IDLE;
      end else if (cs_fall) begin
        state <= ST_OPC; addr_sh <= '0; idx <= '0; dcnt <= '0;
      end else if (byte_done) begin
        case (state)
          ST_OPC: begin
            info <= info_now;
            if (!info_now.known)        state <= ST_IGNORE;
            else if (info_now.has_addr) state <= ST_ADDR;
            else                        state <= ST_ARMED;
            idx <= '0;
          end
          ST_ADDR: begin
            addr_sh <= addr_full;
            idx     <= idx + 2'd1;
            if (idx == 2'd2) begin
              idx <= '0;
              case (info.kind)
                K_READ:  state <= (info.dummy == 2'd0) ? ST_READ : ST_DUMMY;
                K_PROG:  state <= ST_DATA;
                default: state <= ST_ARMED;
              endcase
            end
          end
          ST_DUMMY: begin
            idx <= idx + 2'd1;
            if (start_dummy) state <= ST_READ;
          end
          ST_DATA: begin
            if (data_take) begin
              dcnt <= dcnt + {{(LEN_W-1){1'b0}}, 1'b1};
              if (wel_q) begin
                wr_valid <= 1'b1;
                wr_data  <= rx_byte;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wel = wel_q;

  // read path
  sfcd_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start_i(read_start), .dual_i(info.dual), .addr_i(start_addr),
    .stop_i(cs_rise | cs_fall), .shift_i(sck_fall & cs_low),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .so_o(spi_so), .so_oe_o(spi_so_oe),
    .io0_o(spi_io0_out), .io0_oe_o(spi_io0_oe));

  // assertions
  p_issue_needs_wel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wel_q) && !wel_q);
  p_write_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wel_q);
  p_issue_at_clean_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise) && $past(rx_boundary));
  p_unknown_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !wr_valid && !rd_req && !spi_so_oe);
  p_len_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_PROG_OTP))
      |-> cmd_len != '0 && cmd_len <= LEN_MAX);
  p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, wr_valid, rd_req}));
  p_wel_moves_at_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel_q) |-> $past(cs_rise));
endmodule

// File: tb/sflash_cmd_decoder_tb.sv
module sflash_cmd_decoder_tb_top;
  localparam int HP = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        so, so_oe, io0, io0_oe, wel;
  logic        cmd_valid, wr_valid, rd_req;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_addr, rd_addr;
  logic [8:0]  cmd_len;
  logic [7:0]  wr_data;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;

  always #4 clk = ~clk;

  sflash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .spi_io0_out(io0), .spi_io0_oe(io0_oe),
    .wel(wel), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  int n_chk = 0, n_bad = 0, n_cmd = 0, n_wr = 0, n_rd = 0;
  logic [2:0]  last_op;
  logic [15:0] last_addr;
  logic [8:0]  last_len;
  logic [7:0]  wr_log [0:299];
  logic        done = 1'b0;

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // array model and monitor, away from the active edge
  always @(negedge clk) begin
    rd_valid = rd_req;
    rd_data  = mem_at(rd_addr);
    if (cmd_valid) begin
      n_cmd++; last_op = cmd_op; last_addr = cmd_addr; last_len = cmd_len;
    end
    if (wr_valid) begin
      if (n_wr < 300) wr_log[n_wr] = wr_data;
      n_wr++;
    end
    if (rd_req) n_rd++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel;
    cs_n = 1'b0; wait_n(HP);
  endtask

  task automatic desel;
    wait_n(HP); cs_n = 1'b1; wait_n(3 * HP);
  endtask

  task automatic bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = b[i]; wait_n(HP); sck = 1'b1; wait_n(HP); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i]; wait_n(HP); r[i] = so; sck = 1'b1; wait_n(HP); sck = 1'b0;
    end
  endtask

  task automatic xfer2(output logic [7:0] r, output logic lane_on);
    lane_on = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wait_n(HP);
      r[7-2*k] = so; r[6-2*k] = io0; lane_on &= io0_oe;
      sck = 1'b1; wait_n(HP); sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, r);
  endtask

  task automatic put_addr(input logic [23:0] a);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask

  task automatic frame1(input logic [7:0] opc);
    sel; put(opc); desel;
  endtask

  task automatic erase_frame(input logic [7:0] opc, input logic [23:0] a, input logic with_a);
    sel; put(opc); if (with_a) put_addr(a); desel;
  endtask

  function automatic logic is_known(input logic [7:0] o);
    case (o)
      8'h03, 8'h0B, 8'h3B, 8'h81, 8'h20, 8'h52, 8'hD8, 8'h60,
      8'hC7, 8'h62, 8'h02, 8'h9B, 8'h06, 8'h04: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic lane;
    int c0, w0, rd0;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // reset state
    chk(wel == 0 && so_oe == 0 && io0_oe == 0 && cmd_valid == 0, "R7 reset", wel, 0);

    // R7 latch set / clear
    frame1(8'h06); chk(wel == 1, "R7 set by 06h", wel, 1);
    frame1(8'h04); chk(wel == 0, "R7 clear by 04h", wel, 0);
    sel; put(8'h06); bits(8'h00, 3); desel;
    chk(wel == 0, "R3 06h closed mid-byte", wel, 0);

    // R2 sweep over unknown opcodes with the latch set
    frame1(8'h06);
    c0 = n_cmd; w0 = n_wr; rd0 = n_rd;
    for (int o = 0; o < 256; o++) begin
      if (!is_known(8'(o))) begin
        sel; put(8'(o)); put(8'h00); desel;
        chk(n_cmd == c0 && n_wr == w0 && n_rd == rd0 && wel == 1,
            "R2 unknown opcode silent", o, 0);
      end
    end

    // R3 partial address, then mid-byte close after address
    c0 = n_cmd;
    sel; put(8'h20); put(8'h00); put(8'h10); desel;
    chk(n_cmd == c0 && wel == 1, "R3 short address", n_cmd - c0, 0);
    sel; put(8'h20); put_addr(24'h001000); bits(8'hFF, 3); desel;
    chk(n_cmd == c0 && wel == 1, "R3 mid-byte close", n_cmd - c0, 0);

    // R1/R8/R11 clean erase with high address bits dropped
    erase_frame(8'h20, 24'h123456, 1'b1);
    chk(n_cmd == c0 + 1 && last_op == 3'd1 && last_addr == 16'h3456,
        "R1 R8 4K erase addr", last_addr, 16'h3456);
    chk(wel == 0, "R11 latch cleared by erase", wel, 0);

    // R11 erase without latch
    c0 = n_cmd;
    erase_frame(8'h81, 24'h000100, 1'b1);
    chk(n_cmd == c0, "R11 erase without latch", n_cmd - c0, 0);

    // R8 opcode to cmd_op mapping
    frame1(8'h06); erase_frame(8'h81, 24'h00ABCD, 1'b1);
    chk(last_op == 3'd0 && last_addr == 16'hABCD && last_len == 0, "R8 81h", last_op, 0);
    frame1(8'h06); erase_frame(8'h52, 24'h008000, 1'b1);
    chk(last_op == 3'd2 && last_addr == 16'h8000, "R8 52h", last_op, 2);
    frame1(8'h06); erase_frame(8'hD8, 24'hFF0000, 1'b1);
    chk(last_op == 3'd2 && last_addr == 16'h0000, "R8 D8h", last_op, 2);
    frame1(8'h06); erase_frame(8'h60, 24'h0, 1'b0);
    chk(last_op == 3'd3 && last_addr == 0, "R8 60h", last_op, 3);
    frame1(8'h06); erase_frame(8'hC7, 24'h0, 1'b0);
    chk(last_op == 3'd3, "R8 C7h", last_op, 3);
    c0 = n_cmd;
    frame1(8'h06); erase_frame(8'h62, 24'h0, 1'b0);
    chk(last_op == 3'd3 && n_cmd == c0 + 1, "R8 62h", n_cmd - c0, 1);

    // R9 program with data
    frame1(8'h06); w0 = n_wr;
    sel; put(8'h02); put_addr(24'h340120); put(8'h11); put(8'hC3); put(8'h7E); desel;
    chk(n_wr == w0 + 3 && wr_log[w0] == 8'h11 && wr_log[w0+1] == 8'hC3 && wr_log[w0+2] == 8'h7E,
        "R9 data bytes", n_wr - w0, 3);
    chk(last_op == 3'd4 && last_addr == 16'h0120 && last_len == 3, "R9 program issue", last_len, 3);
    frame1(8'h06);
    sel; put(8'h9B); put_addr(24'h000040); put(8'h5A); desel;
    chk(last_op == 3'd5 && last_len == 1 && last_addr == 16'h0040, "R9 OTP program", last_op, 5);
    frame1(8'h06); c0 = n_cmd;
    sel; put(8'h02); put_addr(24'h000010); desel;
    chk(n_cmd == c0 && wel == 1, "R9 no data byte", n_cmd - c0, 0);

    // R10 long program
    w0 = n_wr;
    sel; put(8'h02); put_addr(24'h000000);
    for (int i = 0; i < 258; i++) put(8'(i * 7 + 1));
    desel;
    chk(n_wr == w0 + 256 && last_len == 9'd256 && last_op == 3'd4, "R10 byte ceiling", n_wr - w0, 256);
    chk(wr_log[w0 + 255] == 8'(255 * 7 + 1), "R10 last kept byte", wr_log[w0 + 255], 8'(255 * 7 + 1));

    // R11 program without latch
    w0 = n_wr; c0 = n_cmd;
    sel; put(8'h02); put_addr(24'h000200); put(8'h99); desel;
    chk(n_wr == w0 && n_cmd == c0, "R11 program without latch", n_wr - w0, 0);

    // R4 plain read
    sel; put(8'h03); put_addr(24'h661230);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      chk(r == mem_at(16'h1230 + 16'(i)), "R4 03h read", r, mem_at(16'h1230 + 16'(i)));
    end
    chk(so_oe == 1 && io0_oe == 0, "R6 single lane enables", io0_oe, 0);
    desel;
    chk(so_oe == 0, "R6 enable drops", so_oe, 0);

    // R4 read with dummy byte
    sel; put(8'h0B); put_addr(24'h00BEEF); put(8'h00);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      chk(r == mem_at(16'hBEEF + 16'(i)), "R4 0Bh read", r, mem_at(16'hBEEF + 16'(i)));
    end
    desel;

    // R5 wrap
    sel; put(8'h03); put_addr(24'hABFFFE);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      chk(r == mem_at(16'hFFFE + 16'(i)), "R5 address wrap", r, mem_at(16'hFFFE + 16'(i)));
    end
    desel;

    // R6 dual read
    sel; put(8'h3B); put_addr(24'h004321); put(8'h00);
    for (int i = 0; i < 4; i++) begin
      xfer2(r, lane);
      chk(r == mem_at(16'h4321 + 16'(i)), "R6 dual read", r, mem_at(16'h4321 + 16'(i)));
      chk(lane == 1, "R6 lane enable", lane, 1);
    end
    desel;
    chk(io0_oe == 0, "R6 lane released", io0_oe, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule